// File: doc/BRIEF.md
# Converter Fault Supervisor

This block collects the fault detections of a switching converter controller and applies a fixed reaction to each one. The sense inputs are supply, input-voltage and output-voltage codes from an ADC. There are also two current-sense comparator flags, a gate-on indication from the driver, a timebase tick and a phase flag that separates start-up from regulated operation. The block answers in one of three ways. It can cut the present switching cycle short, which is peak-current limiting. It can stop switching and start again after a programmed delay. Or it can stop switching and hold off until the supply collapses.

Supply undervoltage lockout uses two thresholds with hysteresis between them. Every start, the first one and each later one, needs the input voltage to sit inside a programmed brown-in window. The primary overcurrent check is blanked at the leading edge of each gate pulse. The secondary overcurrent check counts only when it lasts long enough. The output undervoltage check is active only in regulated operation and must persist for a blanking time. A status code records the first shutdown fault since the last start.

Top module: `prot_supervisor`

## Requirements
- R1: The supply-good state turns on when `vcc_code` >= `cfg_vcc_on` and turns off when `vcc_code` < `cfg_vcc_off`. At levels between the two thresholds the state is kept. A loss of supply-good forces switching off (`gate_en` low) two cycles after the supply code drops.
- R2: A start happens only while supply-good holds and `cfg_vin_start_min` <= `vin_code` <= `cfg_vin_start_max`. At each start `gate_en` rises and `restart_req` is high for that one cycle.
- R3: Latch faults are: `vin_code` > `cfg_vin_ov`, a qualified second overcurrent, and `vout_code` > `cfg_vout_ov` with `cfg_ovp_latch`=1. Each one drops `gate_en` and raises `latched` one cycle after it is seen. The block stays latched until supply-good is lost, and status is held until the next start.
- R4: `cyc_term` is high while switching is enabled, `sw_on` and `cs_ocp1` are high, and `sw_on` has already been high for at least `cfg_leb_cyc` cycles. The first `cfg_leb_cyc` cycles of each gate pulse are blanked.
- R5: `cs_ocp2` causes a latch only when it stays high on more than `cfg_ocp2_cyc` consecutive clock edges. A shorter burst has no effect.
- R6: Output undervoltage is `vout_code` < `cfg_vout_dim_min`/2, counted only while `phase_reg`=1. It causes an auto-restart once the condition has lasted `cfg_uv_blank` ticks. Cycles without `tick` do not count.
- R7: Input brown-out (`vin_code` < `cfg_vin_uv`) causes an auto-restart. After a shutdown, the restart comes `cfg_restart_slow` ticks after the wait begins, plus one cycle, and only when the input is inside the brown-in window. If the input is outside, the block keeps waiting.
- R8: Output overvoltage with `cfg_ovp_latch`=0 causes an auto-restart. With `cfg_ovp_fast`=1 that restart uses `cfg_restart_fast` in place of `cfg_restart_slow`.
- R9: When faults coincide, a latch fault beats an auto-restart fault, and any shutdown fault suppresses `cyc_term` in the same cycle. Among latch faults the order is input OV, then OCP2, then output OV. Among auto-restart faults the order is input UV, then output UV, then output OV.
- R10: `fault_code` reads 0 when there is no fault and whenever switching is on. The other codes are 1 input OV, 2 OCP2, 3 output OV (latched), 4 input UV, 5 output UV and 6 output OV (auto). The code is set by the first shutdown fault, and faults that arrive while switching is off do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable for the slow timers |
| sw_on | input | 1 | Gate pulse currently on (from driver) |
| cs_ocp1 | input | 1 | Primary overcurrent comparator |
| cs_ocp2 | input | 1 | Secondary overcurrent comparator |
| phase_reg | input | 1 | 1 = regulated phase, 0 = start-up |
| vcc_code | input | ADC_W | Supply voltage code |
| vin_code | input | ADC_W | Input voltage code |
| vout_code | input | ADC_W | Output voltage code |
| cfg_vcc_on | input | ADC_W | Supply turn-on threshold |
| cfg_vcc_off | input | ADC_W | Supply turn-off threshold |
| cfg_vin_ov | input | ADC_W | Input overvoltage threshold |
| cfg_vin_uv | input | ADC_W | Input brown-out threshold |
| cfg_vin_start_min | input | ADC_W | Brown-in window low edge |
| cfg_vin_start_max | input | ADC_W | Brown-in window high edge |
| cfg_vout_ov | input | ADC_W | Output overvoltage threshold |
| cfg_vout_dim_min | input | ADC_W | Minimum dimmed output code (UV at half) |
| cfg_ovp_latch | input | 1 | Output OV reaction: 1 latch, 0 auto-restart |
| cfg_ovp_fast | input | 1 | Output OV auto-restart uses the fast delay |
| cfg_leb_cyc | input | LEB_W | Leading-edge blanking, clock cycles |
| cfg_ocp2_cyc | input | OCP2_W | OCP2 qualifying duration, clock cycles |
| cfg_uv_blank | input | BLANK_W | Output UV blanking, ticks |
| cfg_restart_slow | input | TMR_W | Normal restart delay, ticks |
| cfg_restart_fast | input | TMR_W | Fast restart delay, ticks |
| gate_en | output | 1 | Switching allowed |
| cyc_term | output | 1 | End the present switching cycle |
| restart_req | output | 1 | One-cycle pulse at each start |
| fault_code | output | 3 | First shutdown fault since last start |
| latched | output | 1 | Latched shutdown active |

## Verification
The embedded assertions check several properties on every cycle. Supply-good may only change when the code is on the matching side of its threshold. Each gate enable rise comes with a restart pulse one cycle long. A latch holds while the supply is good. Cycle termination appears only while switching is enabled. The first cycle of a gate pulse and the first cycle of an overcurrent burst never trip. The status reads zero while running, and a latch carries a latch-class code.

Some behaviour only the bench scenarios can show. These are the exact restart delays (slow and fast), blocking by the brown-in window, priority between faults that arrive together, disabling of the undervoltage check in the start-up phase and its freezing without ticks, rejection of a short overcurrent burst, and the rule that the first fault is kept.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LATCH = 2'd3
  } sup_state_e;

  typedef enum logic [2:0] {
    FC_NONE      = 3'd0,
    FC_VIN_OV    = 3'd1,
    FC_OCP2      = 3'd2,
    FC_VOUT_OV_L = 3'd3,
    FC_VIN_UV    = 3'd4,
    FC_VOUT_UV   = 3'd5,
    FC_VOUT_OV_A = 3'd6
  } fault_code_e;

endpackage

// File: rtl/prot_uvlo.sv
module prot_uvlo #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vcc,
  input  logic [W-1:0] on_th,
  input  logic [W-1:0] off_th,
  output logic         ok
);

  logic ok_d;

  always_comb begin
    ok_d = ok;
    if (!ok && (vcc >= on_th)) begin
      ok_d = 1'b1;
    end else if (ok && (vcc < off_th)) begin
      ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok <= 1'b0;
    end else begin
      ok <= ok_d;
    end
  end

  AST_UVLO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> $past(vcc >= on_th)); // R1
  AST_UVLO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ok) |-> $past(vcc < off_th)); // R1

endmodule

// File: rtl/prot_dwell.sv
module prot_dwell #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cond,
  input  logic          step,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !cond) begin
      cnt_d = '0;
    end else if (step && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign hit = cond && !clr && (cnt_q >= limit);

  AST_DWELL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cond) && (limit != '0)) |-> !hit); // R5

endmodule

// File: rtl/prot_leb.sv
module prot_leb #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_on,
  input  logic          cs_ocp1,
  input  logic          enable,
  input  logic [LW-1:0] leb_t,
  output logic          term
);

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!sw_on) begin
      cnt_d = '0;
    end else if (cnt_q < leb_t) begin
      cnt_d = cnt_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign term = enable && sw_on && cs_ocp1 && (cnt_q >= leb_t);

  AST_LEB_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sw_on) && (leb_t != '0)) |-> !term); // R4

endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor #(
  parameter int ADC_W   = 10,
  parameter int LEB_W   = 6,
  parameter int OCP2_W  = 8,
  parameter int BLANK_W = 12,
  parameter int TMR_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               sw_on,
  input  logic               cs_ocp1,
  input  logic               cs_ocp2,
  input  logic               phase_reg,
  input  logic [ADC_W-1:0]   vcc_code,
  input  logic [ADC_W-1:0]   vin_code,
  input  logic [ADC_W-1:0]   vout_code,
  input  logic [ADC_W-1:0]   cfg_vcc_on,
  input  logic [ADC_W-1:0]   cfg_vcc_off,
  input  logic [ADC_W-1:0]   cfg_vin_ov,
  input  logic [ADC_W-1:0]   cfg_vin_uv,
  input  logic [ADC_W-1:0]   cfg_vin_start_min,
  input  logic [ADC_W-1:0]   cfg_vin_start_max,
  input  logic [ADC_W-1:0]   cfg_vout_ov,
  input  logic [ADC_W-1:0]   cfg_vout_dim_min,
  input  logic               cfg_ovp_latch,
  input  logic               cfg_ovp_fast,
  input  logic [LEB_W-1:0]   cfg_leb_cyc,
  input  logic [OCP2_W-1:0]  cfg_ocp2_cyc,
  input  logic [BLANK_W-1:0] cfg_uv_blank,
  input  logic [TMR_W-1:0]   cfg_restart_slow,
  input  logic [TMR_W-1:0]   cfg_restart_fast,
  output logic               gate_en,
  output logic               cyc_term,
  output logic               restart_req,
  output logic [2:0]         fault_code,
  output logic               latched
);
  import prot_pkg::*;

  localparam logic [TMR_W-1:0] WCNT_MAX = '1;
  localparam int               RS_DEPTH = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RS_DEPTH-1:0] rs_q;
  logic                rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[RS_DEPTH-2:0], 1'b1};
    end
  end
  assign rst_n_i = rs_q[RS_DEPTH-1];

  sup_state_e       state_q, state_d;
  fault_code_e      code_q, code_d;
  logic             fast_q, fast_d;
  logic [TMR_W-1:0] wcnt_q, wcnt_d;
  logic             restart_q, restart_d;

  logic uvlo_ok;
  logic run;
  logic ocp2_hit;
  logic uv_hit;
  logic uv_cond;
  logic vin_ov, vin_uv, vout_ov, vin_ok;
  logic shut;
  fault_code_e latch_code, auto_code;
  logic [TMR_W-1:0] wait_lim;

  assign run = (state_q == ST_RUN);

  prot_uvlo #(.W(ADC_W)) u_uvlo (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .vcc    (vcc_code),
    .on_th  (cfg_vcc_on),
    .off_th (cfg_vcc_off),
    .ok     (uvlo_ok)
  );

  prot_dwell #(.CW(OCP2_W)) u_ocp2 (
    .clk   (clk),
    .rst_n (rst_n_i),
    .cond  (cs_ocp2),
    .step  (1'b1),
    .clr   (!run),
    .limit (cfg_ocp2_cyc),
    .hit   (ocp2_hit)
  );

  assign uv_cond = phase_reg && (vout_code < (cfg_vout_dim_min >> 1));

  prot_dwell #(.CW(BLANK_W)) u_uvblank (
    .clk   (clk),
    .rst_n (rst_n_i),
    .cond  (uv_cond),
    .step  (tick),
    .clr   (!run),
    .limit (cfg_uv_blank),
    .hit   (uv_hit)
  );

  assign vin_ov  = vin_code > cfg_vin_ov;
  assign vin_uv  = vin_code < cfg_vin_uv;
  assign vout_ov = vout_code > cfg_vout_ov;
  assign vin_ok  = (vin_code >= cfg_vin_start_min) && (vin_code <= cfg_vin_start_max);

  // fault resolution: fixed priority inside each reaction class
  always_comb begin
    latch_code = FC_NONE;
    if (vin_ov) begin
      latch_code = FC_VIN_OV;
    end else if (ocp2_hit) begin
      latch_code = FC_OCP2;
    end else if (vout_ov && cfg_ovp_latch) begin
      latch_code = FC_VOUT_OV_L;
    end
  end

  always_comb begin
    auto_code = FC_NONE;
    if (vin_uv) begin
      auto_code = FC_VIN_UV;
    end else if (uv_hit) begin
      auto_code = FC_VOUT_UV;
    end else if (vout_ov && !cfg_ovp_latch) begin
      auto_code = FC_VOUT_OV_A;
    end
  end

  assign shut = run && ((latch_code != FC_NONE) || (auto_code != FC_NONE));

  prot_leb #(.LW(LEB_W)) u_leb (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .sw_on   (sw_on),
    .cs_ocp1 (cs_ocp1),
    .enable  (run && !shut),
    .leb_t   (cfg_leb_cyc),
    .term    (cyc_term)
  );

  assign wait_lim = fast_q ? cfg_restart_fast : cfg_restart_slow;

  always_comb begin
    state_d   = state_q;
    code_d    = code_q;
    fast_d    = fast_q;
    wcnt_d    = wcnt_q;
    restart_d = 1'b0;
    if (!uvlo_ok) begin
      state_d = ST_OFF;
      wcnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (vin_ok) begin
            state_d   = ST_RUN;
            restart_d = 1'b1;
            code_d    = FC_NONE;
          end
        end
        ST_RUN: begin
          if (latch_code != FC_NONE) begin
            state_d = ST_LATCH;
            code_d  = latch_code;
          end else if (auto_code != FC_NONE) begin
            state_d = ST_WAIT;
            code_d  = auto_code;
            fast_d  = (auto_code == FC_VOUT_OV_A) && cfg_ovp_fast;
            wcnt_d  = '0;
          end
        end
        ST_WAIT: begin
          if ((wcnt_q >= wait_lim) && vin_ok) begin
            state_d   = ST_RUN;
            restart_d = 1'b1;
            code_d    = FC_NONE;
          end else if (tick && (wcnt_q != WCNT_MAX)) begin
            wcnt_d = wcnt_q + TMR_W'(1);
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q   <= ST_OFF;
      code_q    <= FC_NONE;
      fast_q    <= 1'b0;
      wcnt_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      code_q    <= code_d;
      fast_q    <= fast_d;
      wcnt_q    <= wcnt_d;
      restart_q <= restart_d;
    end
  end

  assign gate_en     = run;
  assign latched     = (state_q == ST_LATCH);
  assign restart_req = restart_q;
  assign fault_code  = code_q;

  AST_UVLO_GATE: assert property (@(posedge clk) disable iff (!rst_n_i)
    !uvlo_ok |=> !gate_en); // R1
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(gate_en) |-> restart_req); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    restart_req |=> !restart_req); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n_i)
    (latched && uvlo_ok) |=> latched); // R3
  AST_TERM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n_i)
    cyc_term |-> gate_en); // R4
  AST_LATCH_CLASS: assert property (@(posedge clk) disable iff (!rst_n_i)
    latched |-> (fault_code inside {3'd1, 3'd2, 3'd3})); // R9
  AST_RUN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n_i)
    gate_en |-> (fault_code == 3'd0)); // R10

endmodule

// File: tb/prot_supervisor_tb.sv
`timescale 1ns/1ps
module prot_supervisor_tb;

  logic clk;
  logic rst_n;
  logic tick, sw_on, cs_ocp1, cs_ocp2, phase_reg;
  logic [9:0] vcc_code, vin_code, vout_code;
  logic [9:0] cfg_vcc_on, cfg_vcc_off, cfg_vin_ov, cfg_vin_uv;
  logic [9:0] cfg_vin_start_min, cfg_vin_start_max, cfg_vout_ov, cfg_vout_dim_min;
  logic cfg_ovp_latch, cfg_ovp_fast;
  logic [5:0]  cfg_leb_cyc;
  logic [7:0]  cfg_ocp2_cyc;
  logic [11:0] cfg_uv_blank;
  logic [15:0] cfg_restart_slow, cfg_restart_fast;
  logic gate_en, cyc_term, restart_req, latched;
  logic [2:0] fault_code;

  prot_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_on(sw_on),
    .cs_ocp1(cs_ocp1), .cs_ocp2(cs_ocp2), .phase_reg(phase_reg),
    .vcc_code(vcc_code), .vin_code(vin_code), .vout_code(vout_code),
    .cfg_vcc_on(cfg_vcc_on), .cfg_vcc_off(cfg_vcc_off),
    .cfg_vin_ov(cfg_vin_ov), .cfg_vin_uv(cfg_vin_uv),
    .cfg_vin_start_min(cfg_vin_start_min), .cfg_vin_start_max(cfg_vin_start_max),
    .cfg_vout_ov(cfg_vout_ov), .cfg_vout_dim_min(cfg_vout_dim_min),
    .cfg_ovp_latch(cfg_ovp_latch), .cfg_ovp_fast(cfg_ovp_fast),
    .cfg_leb_cyc(cfg_leb_cyc), .cfg_ocp2_cyc(cfg_ocp2_cyc),
    .cfg_uv_blank(cfg_uv_blank), .cfg_restart_slow(cfg_restart_slow),
    .cfg_restart_fast(cfg_restart_fast),
    .gate_en(gate_en), .cyc_term(cyc_term), .restart_req(restart_req),
    .fault_code(fault_code), .latched(latched)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         c;
    string      req;
    logic       ge;
    logic       ct;
    logic       rr;
    logic [2:0] fc;
    logic       lt;
  } exp_t;

  exp_t sb[$];
  int n_tests = 0;
  int n_fail  = 0;

  // monitor: compare the head of the queue in the cycle it names
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].c <= cyc) begin
      e = sb.pop_front();
      n_tests++;
      if (e.c < cyc) begin
        n_fail++;
        $display("FAIL %s missed cycle %0d actual none expected sample", e.req, e.c);
      end else if (gate_en !== e.ge || cyc_term !== e.ct || restart_req !== e.rr ||
                   fault_code !== e.fc || latched !== e.lt) begin
        n_fail++;
        $display("FAIL %s cyc=%0d actual ge=%b ct=%b rr=%b fc=%0d lt=%b expected ge=%b ct=%b rr=%b fc=%0d lt=%b",
                 e.req, cyc, gate_en, cyc_term, restart_req, fault_code, latched,
                 e.ge, e.ct, e.rr, e.fc, e.lt);
      end
    end
  end

  task automatic push(input int c, input string req, input logic ge, input logic ct,
                      input logic rr, input logic [2:0] fc, input logic lt);
    exp_t e;
    e.c = c; e.req = req; e.ge = ge; e.ct = ct; e.rr = rr; e.fc = fc; e.lt = lt;
    sb.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) step();
  endtask

  task automatic repower();
    int t;
    vcc_code = 10'd0;
    t = cyc;
    wait_until(t + 3);
    vcc_code = 10'd650;
    t = cyc;
    wait_until(t + 4);
    push(cyc, "R2", 1, 0, 0, 3'd0, 0);
    step();
  endtask

  initial begin
    int t;
    rst_n = 1'b0;
    tick = 1'b1; sw_on = 1'b0; cs_ocp1 = 1'b0; cs_ocp2 = 1'b0; phase_reg = 1'b0;
    vcc_code = 10'd0; vin_code = 10'd500; vout_code = 10'd500;
    cfg_vcc_on = 10'd600; cfg_vcc_off = 10'd400;
    cfg_vin_ov = 10'd900; cfg_vin_uv = 10'd200;
    cfg_vin_start_min = 10'd300; cfg_vin_start_max = 10'd800;
    cfg_vout_ov = 10'd700; cfg_vout_dim_min = 10'd400;
    cfg_ovp_latch = 1'b1; cfg_ovp_fast = 1'b0;
    cfg_leb_cyc = 6'd3; cfg_ocp2_cyc = 8'd4; cfg_uv_blank = 12'd5;
    cfg_restart_slow = 16'd6; cfg_restart_fast = 16'd2;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // reset state
    push(cyc, "R1", 0, 0, 0, 3'd0, 0);
    step();

    // R1: between thresholds from off stays off; above on threshold starts
    vcc_code = 10'd500; t = cyc;
    push(t + 3, "R1", 0, 0, 0, 3'd0, 0);
    wait_until(t + 4);
    vcc_code = 10'd600; t = cyc;
    push(t + 2, "R2", 1, 0, 1, 3'd0, 0);
    push(t + 3, "R2", 1, 0, 0, 3'd0, 0);
    wait_until(t + 4);
    vcc_code = 10'd450; t = cyc;
    push(t + 3, "R1", 1, 0, 0, 3'd0, 0);
    wait_until(t + 4);
    vcc_code = 10'd399; t = cyc;
    push(t + 1, "R1", 1, 0, 0, 3'd0, 0);
    push(t + 2, "R1", 0, 0, 0, 3'd0, 0);
    wait_until(t + 3);

    // R2: brown-in window blocks the start
    vin_code = 10'd250; vcc_code = 10'd650; t = cyc;
    push(t + 4, "R2", 0, 0, 0, 3'd0, 0);
    wait_until(t + 5);
    vin_code = 10'd850; t = cyc;
    push(t + 2, "R2", 0, 0, 0, 3'd0, 0);
    wait_until(t + 3);
    vin_code = 10'd500; t = cyc;
    push(t + 1, "R2", 1, 0, 1, 3'd0, 0);
    wait_until(t + 3);

    // R4: leading-edge blanking
    cs_ocp1 = 1'b1; t = cyc;
    push(t, "R4", 1, 0, 0, 3'd0, 0);
    step();
    sw_on = 1'b1; t = cyc;
    push(t,     "R4", 1, 0, 0, 3'd0, 0);
    push(t + 1, "R4", 1, 0, 0, 3'd0, 0);
    push(t + 2, "R4", 1, 0, 0, 3'd0, 0);
    push(t + 3, "R4", 1, 1, 0, 3'd0, 0);
    wait_until(t + 4);
    sw_on = 1'b0;
    push(cyc, "R4", 1, 0, 0, 3'd0, 0);
    step();
    cs_ocp1 = 1'b0;

    // R5: short burst ignored, long burst latches
    cs_ocp2 = 1'b1; t = cyc;
    wait_until(t + 4);
    cs_ocp2 = 1'b0;
    push(t + 5, "R5", 1, 0, 0, 3'd0, 0);
    wait_until(t + 7);
    cs_ocp2 = 1'b1; t = cyc;
    push(t + 4, "R5", 1, 0, 0, 3'd0, 0);
    push(t + 5, "R5", 0, 0, 0, 3'd2, 1);
    wait_until(t + 6);
    cs_ocp2 = 1'b0;

    // R3: latch holds at mid supply, clears only on supply collapse
    vcc_code = 10'd450; t = cyc;
    push(t + 6, "R3", 0, 0, 0, 3'd2, 1);
    wait_until(t + 7);
    vcc_code = 10'd399; t = cyc;
    push(t + 2, "R3", 0, 0, 0, 3'd2, 0);
    wait_until(t + 3);
    vcc_code = 10'd650; t = cyc;
    push(t + 2, "R10", 1, 0, 1, 3'd0, 0);
    wait_until(t + 3);

    // R9: latch beats auto-restart and cycle termination
    sw_on = 1'b1;
    repeat (4) step();
    vin_code = 10'd950; vout_code = 10'd750; cfg_ovp_latch = 1'b0; cs_ocp1 = 1'b1; t = cyc;
    push(t,     "R9", 1, 0, 0, 3'd0, 0);
    push(t + 1, "R9", 0, 0, 0, 3'd1, 1);
    wait_until(t + 2);
    vin_code = 10'd500; vout_code = 10'd500; sw_on = 1'b0; cs_ocp1 = 1'b0;
    repower();

    // R7 + R9: brown-out beats termination, restart waits for window
    sw_on = 1'b1;
    repeat (4) step();
    vin_code = 10'd150; cs_ocp1 = 1'b1; t = cyc;
    push(t,     "R9", 1, 0, 0, 3'd0, 0);
    push(t + 1, "R7", 0, 0, 0, 3'd4, 0);
    wait_until(t + 1);
    vin_code = 10'd250; sw_on = 1'b0; cs_ocp1 = 1'b0;
    push(t + 12, "R7", 0, 0, 0, 3'd4, 0);
    wait_until(t + 12);
    vin_code = 10'd500;
    push(t + 13, "R7", 1, 0, 1, 3'd0, 0);
    wait_until(t + 15);

    // R7: slow restart delay exact
    vin_code = 10'd150; t = cyc;
    wait_until(t + 1);
    vin_code = 10'd500;
    push(t + 7, "R7", 0, 0, 0, 3'd4, 0);
    push(t + 8, "R7", 1, 0, 1, 3'd0, 0);
    wait_until(t + 10);

    // R6: threshold edge, start-up phase, tick gating, blanking
    vout_code = 10'd150; phase_reg = 1'b0; t = cyc;
    push(t + 10, "R6", 1, 0, 0, 3'd0, 0);
    wait_until(t + 11);
    phase_reg = 1'b1; vout_code = 10'd200; t = cyc;
    push(t + 10, "R6", 1, 0, 0, 3'd0, 0);
    wait_until(t + 11);
    tick = 1'b0; vout_code = 10'd150; t = cyc;
    push(t + 10, "R6", 1, 0, 0, 3'd0, 0);
    wait_until(t + 11);
    tick = 1'b1; t = cyc;
    push(t + 5, "R6", 1, 0, 0, 3'd0, 0);
    push(t + 6, "R6", 0, 0, 0, 3'd5, 0);
    wait_until(t + 7);
    vout_code = 10'd500; phase_reg = 1'b0;
    push(t + 12, "R6", 0, 0, 0, 3'd5, 0);
    push(t + 13, "R6", 1, 0, 1, 3'd0, 0);
    wait_until(t + 15);

    // R8: output OV auto-restart, slow delay, first fault kept
    vout_code = 10'd750; t = cyc;
    push(t + 1, "R8", 0, 0, 0, 3'd6, 0);
    wait_until(t + 1);
    vout_code = 10'd500;
    wait_until(t + 2);
    vin_code = 10'd950;
    push(t + 4, "R10", 0, 0, 0, 3'd6, 0);
    wait_until(t + 5);
    vin_code = 10'd500;
    push(t + 7, "R8", 0, 0, 0, 3'd6, 0);
    push(t + 8, "R8", 1, 0, 1, 3'd0, 0);
    wait_until(t + 10);

    // R8: fast delay
    cfg_ovp_fast = 1'b1;
    vout_code = 10'd750; t = cyc;
    wait_until(t + 1);
    vout_code = 10'd500;
    push(t + 3, "R8", 0, 0, 0, 3'd6, 0);
    push(t + 4, "R8", 1, 0, 1, 3'd0, 0);
    wait_until(t + 6);

    // R3: output OV with latch reaction
    cfg_ovp_latch = 1'b1;
    vout_code = 10'd750; t = cyc;
    push(t + 1, "R3", 0, 0, 0, 3'd3, 1);
    wait_until(t + 2);
    vout_code = 10'd500;
    push(t + 8, "R3", 0, 0, 0, 3'd3, 1);
    wait_until(t + 9);
    repower();

    repeat (4) step();
    if (sb.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL scoreboard actual %0d pending expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

endmodule